// File: doc/BRIEF.md
# Block-Gap Pause and Resume Controller

This block sequences a multi-block card data transfer so that software can pause it cleanly between two blocks and restart it later. A one-cycle start pulse loads the number of blocks and the direction. The data path reports each finished block with a strobe. While the controller is running it grants the data path permission to move the next block. It withholds that grant while it is idle or halted.

A level-sensitive stop request is sampled only at block boundaries. At that point the transfer halts if the direction permits it. Writes always permit a halt. Reads permit a halt only when read-wait is enabled. Halting raises the sticky transfer-complete flag and a one-cycle gap event. While halted, the remaining block count is kept. Only an explicit continue pulse resumes the transfer, and it is accepted only while the stop request is low. Four activity flags report reading, writing, data-line busy and data-command inhibit. They drop while halted and return on resume.

Top module: `blkgap_ctrl`

## Requirements
- R1: A start pulse while idle with a nonzero block count loads that count and the direction and begins running (grant high). A start while running, halted, or with a zero count is ignored.
- R2: A halt happens only at a block gap. The stop request is examined only in the cycle a block-done strobe arrives, so a block in progress is never cut short.
- R3: For a write transfer (direction input high), a stop request present at a gap that is not the last block always halts the transfer.
- R4: For a read transfer (direction input low), a stop request halts at a gap only when read-wait enable is high in that cycle. Otherwise the read keeps running.
- R5: Entering the halted state sets transfer-complete and raises the gap event for exactly one cycle.
- R6: While halted, lowering the stop request without a continue pulse leaves the controller halted.
- R7: A continue pulse resumes a halted transfer only when the stop request is low in the same cycle. With the stop request high, the pulse is ignored.
- R8: Read-active is high only while running a read. Write-active is high only while running a write. Data-line-active and data-command-inhibit are high exactly while running. All four are low when idle or halted.
- R9: A stop request that is raised and then withdrawn before the next gap has no effect: the transfer continues and completes normally.
- R10: The remaining block count is held while halted and decremented once per finished block while running. When the last block finishes, the controller goes idle with the count at zero and transfer-complete set, and no gap event fires, even if a stop request is present.
- R11: Transfer-complete stays set until a clear pulse. If a set and a clear fall in the same cycle, the set wins.
- R12: A synchronous active-low reset returns the controller to idle with the count at zero and all flags low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | One-cycle transfer start |
| dir_write_i | input | 1 | Direction captured at start: 1 write, 0 read |
| blk_count_i | input | CNT_W | Number of blocks captured at start |
| stop_req_i | input | 1 | Software stop request level |
| cont_req_i | input | 1 | One-cycle continue request |
| rd_wait_en_i | input | 1 | Read-wait available; allows read halts |
| blk_done_i | input | 1 | Data path strobe: current block finished |
| tc_clr_i | input | 1 | Write-one-to-clear for transfer-complete |
| blk_grant_o | output | 1 | Next block may proceed |
| blk_left_o | output | CNT_W | Remaining block count |
| rd_active_o | output | 1 | Read transfer active |
| wr_active_o | output | 1 | Write transfer active |
| dat_active_o | output | 1 | Data line active |
| dat_inhibit_o | output | 1 | Data command inhibit |
| gap_evt_o | output | 1 | One-cycle block-gap event |
| xfer_done_o | output | 1 | Sticky transfer complete |

## Verification
The main sweep covers every combination of block count from one to five, both directions, and read-wait on or off. Within each combination, the stop request is placed at every possible block, or left off entirely. This separates a halt that was honoured from one that was correctly refused for a read, and a halt at an interior gap from a stop request landing on the final block. At each halt, the bench separates a continue pulse rejected because the stop request is still high from a withdrawn stop request with no continue pulse, and both of these from a real resume with the block count preserved. Directed cases cover a stop request withdrawn before the gap, starts that must be ignored, a same-cycle set and clear of transfer-complete, and reset while halted.

// File: rtl/blkgap_pkg.sv
// Shared types and helpers for the block-gap pause controller.
// Assumes nothing beyond IEEE 1800-2017 packages.
package blkgap_pkg;

    typedef enum logic [1:0] {
        GS_IDLE = 2'd0,
        GS_RUN  = 2'd1,
        GS_HALT = 2'd2
    } gap_state_e;

    // A gap halt is legal for writes always, for reads only with read-wait.
    function automatic logic halt_allowed(input logic is_write, input logic rw_en);
        return is_write | rw_en;
    endfunction

endpackage

// File: rtl/blkgap_count.sv
// Remaining-block counter.
// Loads the requested count at start and decrements once per finished block.
// Assumes the sequencer never decrements a zero count and never loads and
// decrements in the same cycle.
module blkgap_count #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [CNT_W-1:0] load_val_i,
    input  logic             dec_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic             last_o
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    logic [CNT_W-1:0] cnt_q;

    // Hold, load or decrement the remaining count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load_i) begin
            cnt_q <= load_val_i;
        end else if (dec_i) begin
            cnt_q <= cnt_q - ONE;
        end
    end

    // Flag the final block so the sequencer can end instead of halting.
    always_comb begin
        last_o = (cnt_q == ONE);
    end

    assign cnt_o = cnt_q;

    assert_dec_nonzero_R10: assert property (@(posedge clk) disable iff (!rst_n)
        dec_i |-> (cnt_q != '0));

    assert_count_held_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_i && !dec_i) |=> $stable(cnt_q));

endmodule

// File: rtl/blkgap_seq.sv
// Pause/resume sequencer.
// Tracks idle, running and halted states. It samples the stop request only
// at block-done strobes and resumes only on an accepted continue pulse.
// Assumes block-done strobes arrive only while the grant is high.
module blkgap_seq
    import blkgap_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start_i,
    input  logic       count_nz_i,
    input  logic       last_blk_i,
    input  logic       blk_done_i,
    input  logic       stop_req_i,
    input  logic       cont_req_i,
    input  logic       rd_wait_en_i,
    input  logic       dir_write_i,
    output gap_state_e state_o,
    output logic       dir_wr_o,
    output logic       load_o,
    output logic       dec_o,
    output logic       halt_fire_o,
    output logic       end_fire_o
);
    gap_state_e state_q, state_d;
    logic       dir_q;
    logic       resume;

    // Decode the events of this cycle from the current state and inputs.
    always_comb begin
        load_o      = (state_q == GS_IDLE) && start_i && count_nz_i;
        dec_o       = (state_q == GS_RUN) && blk_done_i;
        end_fire_o  = dec_o && last_blk_i;
        halt_fire_o = dec_o && !last_blk_i && stop_req_i &&
                      halt_allowed(dir_q, rd_wait_en_i);
        resume      = (state_q == GS_HALT) && cont_req_i && !stop_req_i;
    end

    // Choose the next state from the decoded events.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            GS_IDLE: if (load_o) state_d = GS_RUN;
            GS_RUN: begin
                if (end_fire_o)       state_d = GS_IDLE;
                else if (halt_fire_o) state_d = GS_HALT;
            end
            GS_HALT: if (resume) state_d = GS_RUN;
            default: state_d = GS_IDLE;
        endcase
    end

    // State register with synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= GS_IDLE;
        else        state_q <= state_d;
    end

    // Capture the direction at start; it holds for the whole transfer.
    always_ff @(posedge clk) begin
        if (!rst_n)      dir_q <= 1'b0;
        else if (load_o) dir_q <= dir_write_i;
    end

    assign state_o  = state_q;
    assign dir_wr_o = dir_q;

    assert_halt_only_at_gap_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == GS_RUN && !blk_done_i) |=> (state_q == GS_RUN));

    assert_read_needs_wait_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == GS_RUN && !dir_q && !rd_wait_en_i) |=> (state_q != GS_HALT));

    assert_no_self_restart_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == GS_HALT && !cont_req_i) |=> (state_q == GS_HALT));

    assert_cont_blocked_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == GS_HALT && stop_req_i) |=> (state_q == GS_HALT));

    assert_start_when_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != GS_IDLE) |=> $stable(dir_q));

endmodule

// File: rtl/blkgap_flags.sv
// Status flag unit.
// Decodes the activity flags from the state, registers the one-cycle gap
// event and holds the sticky transfer-complete bit with write-one-to-clear.
// Assumes halt and end events come from the sequencer in the cycle they occur.
module blkgap_flags
    import blkgap_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  gap_state_e state_i,
    input  logic       dir_wr_i,
    input  logic       halt_fire_i,
    input  logic       end_fire_i,
    input  logic       tc_clr_i,
    output logic       grant_o,
    output logic       rd_active_o,
    output logic       wr_active_o,
    output logic       dat_active_o,
    output logic       dat_inhibit_o,
    output logic       gap_evt_o,
    output logic       xfer_done_o
);
    logic running;
    logic gap_q;
    logic done_q;

    // Activity flags follow the running state and the captured direction.
    always_comb begin
        running       = (state_i == GS_RUN);
        grant_o       = running;
        rd_active_o   = running && !dir_wr_i;
        wr_active_o   = running && dir_wr_i;
        dat_active_o  = running;
        dat_inhibit_o = running;
    end

    // Gap event: one cycle high after each halt.
    always_ff @(posedge clk) begin
        if (!rst_n) gap_q <= 1'b0;
        else        gap_q <= halt_fire_i;
    end

    // Transfer complete: set by halt or end, cleared by software; set wins.
    always_ff @(posedge clk) begin
        if (!rst_n)                         done_q <= 1'b0;
        else if (halt_fire_i || end_fire_i) done_q <= 1'b1;
        else if (tc_clr_i)                  done_q <= 1'b0;
    end

    assign gap_evt_o   = gap_q;
    assign xfer_done_o = done_q;

    assert_gap_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
        gap_q |=> !gap_q);

    assert_gap_sets_done_R5: assert property (@(posedge clk) disable iff (!rst_n)
        gap_q |-> done_q);

    assert_done_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (done_q && !tc_clr_i) |=> done_q);

    assert_flags_onehot_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({rd_active_o, wr_active_o}));

endmodule

// File: rtl/blkgap_ctrl.sv
// Block-gap pause and resume controller, top level.
// Wires the sequencer, the remaining-block counter and the status flags.
// Assumes blk_done_i pulses only while blk_grant_o is high and that
// cont_req_i and start_i are single-cycle pulses.
module blkgap_ctrl
    import blkgap_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             dir_write_i,
    input  logic [CNT_W-1:0] blk_count_i,
    input  logic             stop_req_i,
    input  logic             cont_req_i,
    input  logic             rd_wait_en_i,
    input  logic             blk_done_i,
    input  logic             tc_clr_i,
    output logic             blk_grant_o,
    output logic [CNT_W-1:0] blk_left_o,
    output logic             rd_active_o,
    output logic             wr_active_o,
    output logic             dat_active_o,
    output logic             dat_inhibit_o,
    output logic             gap_evt_o,
    output logic             xfer_done_o
);
    gap_state_e state;
    logic       dir_wr;
    logic       load;
    logic       dec;
    logic       halt_fire;
    logic       end_fire;
    logic       last_blk;
    logic       count_nz;

    // A zero block count never starts a transfer.
    always_comb begin
        count_nz = (blk_count_i != '0);
    end

    blkgap_seq u_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .start_i      (start_i),
        .count_nz_i   (count_nz),
        .last_blk_i   (last_blk),
        .blk_done_i   (blk_done_i),
        .stop_req_i   (stop_req_i),
        .cont_req_i   (cont_req_i),
        .rd_wait_en_i (rd_wait_en_i),
        .dir_write_i  (dir_write_i),
        .state_o      (state),
        .dir_wr_o     (dir_wr),
        .load_o       (load),
        .dec_o        (dec),
        .halt_fire_o  (halt_fire),
        .end_fire_o   (end_fire)
    );

    blkgap_count #(.CNT_W(CNT_W)) u_count (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (load),
        .load_val_i (blk_count_i),
        .dec_i      (dec),
        .cnt_o      (blk_left_o),
        .last_o     (last_blk)
    );

    blkgap_flags u_flags (
        .clk           (clk),
        .rst_n         (rst_n),
        .state_i       (state),
        .dir_wr_i      (dir_wr),
        .halt_fire_i   (halt_fire),
        .end_fire_i    (end_fire),
        .tc_clr_i      (tc_clr_i),
        .grant_o       (blk_grant_o),
        .rd_active_o   (rd_active_o),
        .wr_active_o   (wr_active_o),
        .dat_active_o  (dat_active_o),
        .dat_inhibit_o (dat_inhibit_o),
        .gap_evt_o     (gap_evt_o),
        .xfer_done_o   (xfer_done_o)
    );

    assert_idle_count_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (end_fire) |=> (blk_left_o == '0 && !blk_grant_o));

    assert_inhibit_tracks_R8: assert property (@(posedge clk) disable iff (!rst_n)
        dat_inhibit_o == (rd_active_o || wr_active_o));

endmodule

// File: tb/blkgap_ctrl_bench.sv
// Self-checking bench: sweeps block counts, directions, read-wait and stop
// positions, then runs directed corner cases.
module blkgap_ctrl_bench;
    localparam int CW = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start_i = 1'b0;
    logic          dir_write_i = 1'b0;
    logic [CW-1:0] blk_count_i = '0;
    logic          stop_req_i = 1'b0;
    logic          cont_req_i = 1'b0;
    logic          rd_wait_en_i = 1'b0;
    logic          blk_done_i = 1'b0;
    logic          tc_clr_i = 1'b0;
    logic          blk_grant_o;
    logic [CW-1:0] blk_left_o;
    logic          rd_active_o, wr_active_o, dat_active_o, dat_inhibit_o;
    logic          gap_evt_o, xfer_done_o;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    blkgap_ctrl #(.CNT_W(CW)) u_blkgap_ctrl (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .dir_write_i(dir_write_i),
        .blk_count_i(blk_count_i), .stop_req_i(stop_req_i), .cont_req_i(cont_req_i),
        .rd_wait_en_i(rd_wait_en_i), .blk_done_i(blk_done_i), .tc_clr_i(tc_clr_i),
        .blk_grant_o(blk_grant_o), .blk_left_o(blk_left_o), .rd_active_o(rd_active_o),
        .wr_active_o(wr_active_o), .dat_active_o(dat_active_o),
        .dat_inhibit_o(dat_inhibit_o), .gap_evt_o(gap_evt_o), .xfer_done_o(xfer_done_o)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    // Activity flags expected for a given running state and direction (R8).
    task automatic chk_flags(input string req, input bit run, input bit wr);
        chk(req, "grant", blk_grant_o, run);
        chk("R8", "rd_active", rd_active_o, run && !wr);
        chk("R8", "wr_active", wr_active_o, run && wr);
        chk("R8", "dat_active", dat_active_o, run);
        chk("R8", "dat_inhibit", dat_inhibit_o, run);
    endtask

    task automatic clear_done();
        tc_clr_i = 1'b1; tick(); tc_clr_i = 1'b0;
    endtask

    task automatic begin_xfer(input int n, input bit wr);
        blk_count_i = CW'(n); dir_write_i = wr; start_i = 1'b1;
        tick(); start_i = 1'b0;
    endtask

    // One sweep case: n blocks, direction, read-wait, stop at block s (0 = none).
    task automatic run_case(input int n, input bit wr, input bit rw, input int s);
        clear_done();
        rd_wait_en_i = rw;
        begin_xfer(n, wr);
        chk("R1", "left after start", blk_left_o, n);
        chk_flags("R1", 1'b1, wr);
        for (int b = 1; b <= n; b++) begin
            stop_req_i = (b == s);
            blk_done_i = 1'b1;
            tick();
            blk_done_i = 1'b0;
            if (b == n) begin
                chk_flags("R10", 1'b0, wr);
                chk("R10", "left at end", blk_left_o, 0);
                chk("R10", "no gap at last", gap_evt_o, 0);
                chk("R10", "done at end", xfer_done_o, 1);
                stop_req_i = 1'b0;
            end else if (b == s && (wr || rw)) begin
                chk_flags(wr ? "R3" : "R4", 1'b0, wr);
                chk("R5", "gap pulse", gap_evt_o, 1);
                chk("R5", "done on halt", xfer_done_o, 1);
                chk("R10", "left held", blk_left_o, n - b);
                tick();
                chk("R5", "gap one cycle", gap_evt_o, 0);
                clear_done();
                chk("R11", "done cleared", xfer_done_o, 0);
                cont_req_i = 1'b1; tick(); cont_req_i = 1'b0;
                chk("R7", "cont with stop high", blk_grant_o, 0);
                stop_req_i = 1'b0; tick(); tick();
                chk("R6", "stop dropped no cont", blk_grant_o, 0);
                chk("R10", "left while halted", blk_left_o, n - b);
                cont_req_i = 1'b1; tick(); cont_req_i = 1'b0;
                chk_flags("R7", 1'b1, wr);
                chk("R10", "left after resume", blk_left_o, n - b);
            end else begin
                stop_req_i = 1'b0;
                chk_flags(b == s ? "R4" : "R2", 1'b1, wr);
                chk("R2", "no gap", gap_evt_o, 0);
                chk("R11", "done low running", xfer_done_o, 0);
                chk("R10", "left", blk_left_o, n - b);
            end
        end
        tick();
    endtask

    initial begin
        tick(); tick();
        chk_flags("R12", 1'b0, 1'b0);
        chk("R12", "left reset", blk_left_o, 0);
        chk("R12", "done reset", xfer_done_o, 0);
        rst_n = 1'b1;
        tick();

        for (int n = 1; n <= 5; n++)
            for (int wr = 0; wr < 2; wr++)
                for (int rw = 0; rw < 2; rw++)
                    for (int s = 0; s <= n; s++)
                        run_case(n, wr[0], rw[0], s);

        // R1: zero count does not start; start while running is ignored.
        clear_done();
        begin_xfer(0, 1'b1);
        chk("R1", "zero count no start", blk_grant_o, 0);
        begin_xfer(3, 1'b1);
        begin_xfer(9, 1'b0);
        chk("R1", "restart ignored left", blk_left_o, 3);
        chk("R1", "restart ignored dir", wr_active_o, 1);

        // R9: stop raised then withdrawn before the gap.
        stop_req_i = 1'b1; tick(); tick();
        chk("R2", "no halt mid-block", blk_grant_o, 1);
        stop_req_i = 1'b0; tick();
        blk_done_i = 1'b1; tick(); blk_done_i = 1'b0;
        chk("R9", "withdrawn stop ignored", blk_grant_o, 1);
        chk("R9", "no gap", gap_evt_o, 0);
        blk_done_i = 1'b1; tick(); tick(); blk_done_i = 1'b0;
        chk("R9", "completes", xfer_done_o, 1);
        chk("R9", "idle after", blk_grant_o, 0);

        // R11: set and clear in the same cycle; set wins.
        clear_done();
        begin_xfer(1, 1'b0);
        blk_done_i = 1'b1; tc_clr_i = 1'b1; tick();
        blk_done_i = 1'b0; tc_clr_i = 1'b0;
        chk("R11", "set beats clear", xfer_done_o, 1);
        tick();
        chk("R11", "still sticky", xfer_done_o, 1);

        // R12: reset while halted.
        begin_xfer(4, 1'b1);
        stop_req_i = 1'b1; blk_done_i = 1'b1; tick(); blk_done_i = 1'b0;
        chk("R3", "halted before reset", blk_grant_o, 0);
        rst_n = 1'b0; tick(); rst_n = 1'b1; stop_req_i = 1'b0;
        chk_flags("R12", 1'b0, 1'b0);
        chk("R12", "left cleared", blk_left_o, 0);
        chk("R12", "done cleared", xfer_done_o, 0);
        cont_req_i = 1'b1; tick(); cont_req_i = 1'b0;
        chk("R12", "no resume after reset", blk_grant_o, 0);

        if (!finished) begin
            finished = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            checks++; errors++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule